// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block turns a decoded memory-operand descriptor into a 32-bit byte offset. It adds up to three terms: a base register value, an index register value shifted left by a 2-bit scale code, and a displacement that is absent, a sign-extended byte, or a full 32-bit word. With both register terms off and a full displacement selected, the displacement itself is the address. The sum wraps modulo 2^32.

The same result is checked against the natural alignment of the operand size. Misalignment is only reported and never blocks anything. In the same cycle, and from separate inputs, the block forms a relative branch target: the next-instruction address plus a sign-extended 8-bit offset.

The default build registers every output once. The output valid copies the input valid one cycle later, and a synchronous active-high reset clears all outputs. Register reads, segment translation, protection and the memory access itself are left to neighbouring logic.

Top module: `ea_addr_gen`

## Requirements
- R1: With `use_base`=0, `use_index`=0 and `disp_kind`=2'b10 (32-bit), `ea` equals `disp`.
- R2: `ea` = (`use_base` ? `base_val` : 0) + (`use_index` ? `index_val` << `scale_code` : 0) + displacement term, for every on/off combination of the two register terms.
- R3: With `disp_kind`=2'b01, the displacement term is `disp[7:0]` sign-extended to 32 bits, and `disp[31:8]` has no effect on `ea`.
- R4: `scale_code` 0, 1, 2 and 3 multiply the index term by 1, 2, 4 and 8. The base term is never scaled.
- R5: All additions wrap modulo 2^32, and there is no overflow output.
- R6: With `op_size`=2'b10 or 2'b11 (32-bit), `misalign` is 1 exactly when `ea[1:0]` is not 00.
- R7: With `op_size`=2'b01 (16-bit), `misalign` is 1 exactly when `ea[0]` is 1.
- R8: With `op_size`=2'b00 (8-bit), `misalign` is always 0, whatever the address.
- R9: `br_target` = `next_pc` + `br_off` sign-extended to 32 bits, covering offsets from -128 to +127.
- R10: The outputs appear one clock after the inputs. `out_valid` in a given cycle equals `in_valid` from the previous cycle, and a reset cycle clears `out_valid`, `ea`, `misalign` and `br_target` to 0.
- R11: With `disp_kind`=2'b00, the displacement term is zero and `disp` has no effect on `ea`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor valid |
| use_base | input | 1 | Include the base register term |
| use_index | input | 1 | Include the scaled index term |
| scale_code | input | 2 | Left-shift amount for the index term |
| disp_kind | input | 2 | 00 none, 01 8-bit, 1x 32-bit displacement |
| op_size | input | 2 | 00 byte, 01 16-bit, 1x 32-bit operand |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| disp | input | 32 | Displacement field |
| next_pc | input | 32 | Address of the following instruction |
| br_off | input | 8 | Signed short branch offset |
| out_valid | output | 1 | Results valid |
| ea | output | 32 | Effective address |
| misalign | output | 1 | Natural-alignment violation for `op_size` |
| br_target | output | 32 | Relative branch target |

## Verification
Effective-address generation with its alignment verdict and branch-target formation always land in the same output cycle. The two paths share no inputs, so a fault that crosses them would go unseen if each were tested alone. Every table vector therefore drives a full operand descriptor and a branch pair together. Each vector is then judged on `ea`, `misalign` and `br_target` in the single cycle after it, and the values include offsets at both ends of the signed byte range alongside wrapping, misaligned addresses.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned ADDR_BITS  = 32;
  localparam int unsigned SHORT_BITS = 8;

  localparam logic [1:0] DK_NONE  = 2'b00;
  localparam logic [1:0] DK_SHORT = 2'b01;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
  parameter int unsigned W     = 32,
  parameter int unsigned SHORT = 8
) (
  input  logic [1:0]   kind,
  input  logic [W-1:0] raw,
  output logic [W-1:0] term
);
  import ea_pkg::*;
  localparam int unsigned PAD = W - SHORT;

  always_comb begin
    if (kind == DK_NONE)       term = '0;
    else if (kind == DK_SHORT) term = {{PAD{raw[SHORT-1]}}, raw[SHORT-1:0]};
    else                       term = raw;
  end
endmodule

// File: rtl/ea_index_scaler.sv
module ea_index_scaler #(
  parameter int unsigned W    = 32,
  parameter int unsigned SC_W = 2
) (
  input  logic            en,
  input  logic [SC_W-1:0] code,
  input  logic [W-1:0]    idx,
  output logic [W-1:0]    term
);
  always_comb term = en ? (idx << code) : '0;
endmodule

// File: rtl/ea_align_check.sv
module ea_align_check #(
  parameter int unsigned W = 32
) (
  input  logic [1:0]   size,
  input  logic [W-1:0] addr,
  output logic         mis
);
  import ea_pkg::*;

  always_comb begin
    if (size == SZ_BYTE)      mis = 1'b0;
    else if (size == SZ_HALF) mis = addr[0];
    else                      mis = |addr[1:0];
  end
endmodule

// File: rtl/ea_branch_calc.sv
module ea_branch_calc #(
  parameter int unsigned W     = 32,
  parameter int unsigned OFF_W = 8
) (
  input  logic [W-1:0]     pc,
  input  logic [OFF_W-1:0] off,
  output logic [W-1:0]     target
);
  localparam int unsigned PAD = W - OFF_W;
  always_comb target = pc + {{PAD{off[OFF_W-1]}}, off};
endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SCALE_W  = 2,
  parameter int unsigned BR_OFF_W = 8,
  parameter bit          REG_OUT  = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                use_base,
  input  logic                use_index,
  input  logic [SCALE_W-1:0]  scale_code,
  input  logic [1:0]          disp_kind,
  input  logic [1:0]          op_size,
  input  logic [ADDR_W-1:0]   base_val,
  input  logic [ADDR_W-1:0]   index_val,
  input  logic [ADDR_W-1:0]   disp,
  input  logic [ADDR_W-1:0]   next_pc,
  input  logic [BR_OFF_W-1:0] br_off,
  output logic                out_valid,
  output logic [ADDR_W-1:0]   ea,
  output logic                misalign,
  output logic [ADDR_W-1:0]   br_target
);
  import ea_pkg::*;
  localparam int unsigned BR_PAD = ADDR_W - BR_OFF_W;

  logic [ADDR_W-1:0] base_term, idx_term, disp_term, sum_c, tgt_c;
  logic              mis_c;

  assign base_term = use_base ? base_val : '0;

  ea_index_scaler #(.W(ADDR_W), .SC_W(SCALE_W)) u_scale (
    .en(use_index), .code(scale_code), .idx(index_val), .term(idx_term)
  );

  ea_disp_ext #(.W(ADDR_W), .SHORT(SHORT_BITS)) u_disp (
    .kind(disp_kind), .raw(disp), .term(disp_term)
  );

  assign sum_c = base_term + idx_term + disp_term;

  ea_align_check #(.W(ADDR_W)) u_align (
    .size(op_size), .addr(sum_c), .mis(mis_c)
  );

  ea_branch_calc #(.W(ADDR_W), .OFF_W(BR_OFF_W)) u_branch (
    .pc(next_pc), .off(br_off), .target(tgt_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          ea        <= '0;
          misalign  <= 1'b0;
          br_target <= '0;
        end else begin
          out_valid <= in_valid;
          ea        <= sum_c;
          misalign  <= mis_c;
          br_target <= tgt_c;
        end
      end

      assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      assert_idle_follows_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
      assert_byte_never_mis_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_size == SZ_BYTE) |=> !misalign);
      assert_half_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_size == SZ_HALF) |=> (misalign == ea[0]));
      assert_word_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_size[1]) |=> (misalign == (ea[1:0] != 2'b00)));
      assert_branch_target_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (br_target == $past(next_pc + {{BR_PAD{br_off[BR_OFF_W-1]}}, br_off})));
      assert_direct_mode_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !use_base && !use_index && disp_kind[1]) |=> (ea == $past(disp)));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign ea        = sum_c;
      assign misalign  = mis_c;
      assign br_target = tgt_c;
    end
  endgenerate
endmodule

// File: tb/ea_addr_gen_test.sv
`timescale 1ns/1ps
module ea_addr_gen_test;
  typedef struct packed {
    logic        ub;
    logic        ui;
    logic [1:0]  sc;
    logic [1:0]  dk;
    logic [1:0]  os;
    logic [31:0] base;
    logic [31:0] idx;
    logic [31:0] disp;
    logic [31:0] pc;
    logic [7:0]  off;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0,1'b0,2'd0,2'b10,2'b10,32'h11111111,32'h22222222,32'h00401000,32'h00001000,8'h10},
    '{1'b1,1'b0,2'd0,2'b00,2'b10,32'h80000004,32'h00000100,32'h0000ABCD,32'h00002000,8'h80},
    '{1'b0,1'b1,2'd2,2'b01,2'b01,32'h00000000,32'h00000100,32'h00000080,32'h00003000,8'h7F},
    '{1'b1,1'b1,2'd3,2'b10,2'b10,32'h00001000,32'h00000010,32'h00000003,32'h00000000,8'h80},
    '{1'b1,1'b1,2'd1,2'b01,2'b00,32'h00000005,32'h00000007,32'h000000FF,32'hFFFFFFFF,8'h7F},
    '{1'b1,1'b1,2'd0,2'b11,2'b01,32'hFFFFFFF0,32'h00000020,32'h00000001,32'h7FFFFFF0,8'h20},
    '{1'b1,1'b1,2'd3,2'b00,2'b10,32'hFFFFFFFC,32'h80000001,32'h12345678,32'h00000040,8'hC0},
    '{1'b0,1'b1,2'd3,2'b10,2'b01,32'h0BADF00D,32'h10000000,32'h00000006,32'h80000000,8'hFF},
    '{1'b1,1'b0,2'd2,2'b01,2'b10,32'h00000102,32'hFFFFFFFF,32'hFFFFFF7E,32'h00000005,8'h01},
    '{1'b1,1'b1,2'd2,2'b10,2'b11,32'h00000100,32'h00000004,32'h00000000,32'h0000FFFF,8'h00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, use_base = 1'b0, use_index = 1'b0;
  logic [1:0]  scale_code = '0, disp_kind = '0, op_size = '0;
  logic [31:0] base_val = '0, index_val = '0, disp = '0, next_pc = '0;
  logic [7:0]  br_off = '0;
  logic        out_valid, misalign;
  logic [31:0] ea, br_target;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ea_addr_gen uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .use_base(use_base),
    .use_index(use_index), .scale_code(scale_code), .disp_kind(disp_kind),
    .op_size(op_size), .base_val(base_val), .index_val(index_val), .disp(disp),
    .next_pc(next_pc), .br_off(br_off), .out_valid(out_valid), .ea(ea),
    .misalign(misalign), .br_target(br_target)
  );

  function automatic logic [31:0] model_ea(input vec_t v);
    logic [31:0] d;
    if (v.dk == 2'b00)      d = 32'h0;
    else if (v.dk == 2'b01) d = {{24{v.disp[7]}}, v.disp[7:0]};
    else                    d = v.disp;
    return (v.ub ? v.base : 32'h0) + (v.ui ? (v.idx * (32'd1 << v.sc)) : 32'h0) + d;
  endfunction

  function automatic logic model_mis(input vec_t v);
    logic [31:0] a;
    a = model_ea(v);
    if (v.os == 2'b00)      return 1'b0;
    else if (v.os == 2'b01) return a[0];
    else                    return a[1:0] != 2'b00;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    string mtag;
    @(negedge clk);
    in_valid = 1'b1; use_base = v.ub; use_index = v.ui; scale_code = v.sc;
    disp_kind = v.dk; op_size = v.os; base_val = v.base; index_val = v.idx;
    disp = v.disp; next_pc = v.pc; br_off = v.off;
    @(negedge clk);
    mtag = v.os[1] ? "R6 misalign" : (v.os[0] ? "R7 misalign" : "R8 misalign");
    check({tag, " ea"}, ea, model_ea(v));
    check(mtag, {31'd0, misalign}, {31'd0, model_mis(v)});
    check("R9 branch target", br_target, v.pc + {{24{v.off[7]}}, v.off});
    check("R10 valid", {31'd0, out_valid}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset valid", {31'd0, out_valid}, 32'd0);
    check("R10 reset ea", ea, 32'd0);
    check("R10 reset target", br_target, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VECS[i], "R2");

    // R1: direct 32-bit displacement
    v = '{1'b0,1'b0,2'd3,2'b10,2'b10,32'hFFFFFFFF,32'hFFFFFFFF,32'hCAFE0004,32'h10,8'h04};
    run_vec(v, "R1");
    // R3: upper displacement bits ignored for the short form
    v = '{1'b1,1'b0,2'd0,2'b01,2'b00,32'h00000100,32'h0,32'hFFFFFF05,32'h0,8'h00};
    run_vec(v, "R3");
    check("R3 upper ignored", ea, 32'h00000105);
    v.disp = 32'h000000F0;
    run_vec(v, "R3");
    check("R3 negative short", ea, 32'h000000F0);
    // R4: base is never scaled, index scaled by 8
    v = '{1'b1,1'b1,2'd3,2'b00,2'b10,32'h00000003,32'h00000002,32'h0,32'h0,8'h00};
    run_vec(v, "R4");
    check("R4 scaled index only", ea, 32'h00000013);
    // R5: wrap modulo 2^32
    v = '{1'b1,1'b1,2'd0,2'b10,2'b10,32'hFFFFFFFF,32'h00000001,32'h00000004,32'h0,8'h00};
    run_vec(v, "R5");
    check("R5 wrap", ea, 32'h00000004);
    // R11: no displacement, disp ignored
    v = '{1'b1,1'b0,2'd0,2'b00,2'b10,32'h00000040,32'h0,32'hDEADBEEF,32'h0,8'h00};
    run_vec(v, "R11");
    check("R11 disp ignored", ea, 32'h00000040);
    // R8: byte at odd address
    v = '{1'b1,1'b0,2'd0,2'b00,2'b00,32'h00000007,32'h0,32'h0,32'h0,8'h00};
    run_vec(v, "R8");
    check("R8 byte odd", {31'd0, misalign}, 32'd0);

    // R10: idle cycle drops valid
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R10 idle valid", {31'd0, out_valid}, 32'd0);
    // R10: reset mid-run clears outputs
    in_valid = 1'b1; base_val = 32'h123; use_base = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R10 mid reset valid", {31'd0, out_valid}, 32'd0);
    check("R10 mid reset ea", ea, 32'd0);
    rst = 1'b0;
    in_valid = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule